// File: doc/BRIEF.md
# Daisy-Chained DAC Serial Host

This block is the host end of a serial link that feeds a chain of eight-channel DAC slaves. All slaves share one serial clock and one active-low select; the data output of each slave drives the data input of the next, so the chain acts as one long shift register. A caller presents a target slave index, a 4-bit command, a 4-bit channel address and a 16-bit code, then pulses `start`. The block assembles one 32-bit frame per slave and streams all of them out under a single select window. Every slave that is not the target receives a no-operation frame.

A second mode sends a different command to every slave in the same window. When `use_slots` is high at `start`, each slave's frame is taken from its own 24-bit field of `slot_words`. Serial clock speed is set by a half-period divider parameter, checked at elaboration against a 50 MHz ceiling. Select rises once at the end, so every slave acts on its frame at the same moment. A one-cycle `done` marks the end of the transfer.

Top module: `dac_chain_host`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is 0, `mosi` is 0, and `busy` and `done` are 0.
- R2: Each slave frame is 32 bits sent MSB first: bits 31:24 are zero, 23:20 the command, 19:16 the channel address and 15:0 the code.
- R3: Frames go out in reverse chain order: the frame for slave N_DEV-1 is shifted first and the frame for slave 0 last.
- R4: In single-target mode only slave `dev_idx` gets the caller's frame. Every other slot gets the no-op frame 32'h00F00000 (command 4'hF, address 0, code 0). A `dev_idx` of N_DEV or more sends no-op to every slot.
- R5: When `use_slots` is 1 at `start`, slot i's frame is built from `slot_words[24*i+23:24*i]` = {command, address, code}, and `dev_idx`, `cmd`, `addr` and `code` are ignored. When `use_slots` is 0, `slot_words` is ignored.
- R6: `cs_n` falls once per transfer and stays low across exactly N_DEV*32 rising `sck` edges, then rises once.
- R7: `mosi` changes only at a falling `sck` edge or at the fall of `cs_n`, so it is stable at every rising `sck` edge.
- R8: `sck` idles low whenever `cs_n` is high. Its high and low phases each last HALF_DIV system clock cycles. At least one full `sck` period separates each `cs_n` edge from the nearest `sck` edge.
- R9: `start` is ignored while `busy` is 1: the stream in flight does not change and no second transfer follows.
- R10: `done` is high for exactly one cycle: the first cycle in which `cs_n` is back high. `busy` clears in that same cycle.
- R11: Parameters that would give an `sck` rate above 50 MHz, or a zero chain length or divider, are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| start | input | 1 | Begin a transfer (one cycle) |
| dev_idx | input | IDX_W | Target slave index in single-target mode |
| cmd | input | 4 | Command for the target slave |
| addr | input | 4 | Channel address for the target slave |
| code | input | 16 | DAC code for the target slave |
| use_slots | input | 1 | 1: build every slot from `slot_words` |
| slot_words | input | 24*N_DEV | Per-slot {command, address, code}; slot i at bits 24*i+23:24*i |
| sck | output | 1 | Serial clock to the chain |
| mosi | output | 1 | Serial data to the first slave |
| cs_n | output | 1 | Shared active-low select / load |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The collision of interest is a new `start` request that arrives while the engine is shifting: request acceptance and the shifting sequence meet in the same cycle. The bench raises `start` with a different target and code about a hundred cycles into a transfer. It judges the result by the full captured stream, which must match the first request bit for bit. It also requires that `cs_n` stay high for many cycles after `done`, so that no second transfer has been started. The same transfers also measure the idle gap between select and clock and the total `sck` high time, so divider timing and ordering are judged together.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;

   localparam int FRAME_W = 32;
   localparam int SLOT_W  = 24;
   localparam logic [3:0] CMD_NOP = 4'hF;

   typedef struct packed {
      logic [7:0]  pad;
      logic [3:0]  cmd;
      logic [3:0]  addr;
      logic [15:0] code;
   } dev_frame_t;

   function automatic dev_frame_t pack_frame(logic [SLOT_W-1:0] w);
      dev_frame_t f;
      f.pad  = 8'h00;
      f.cmd  = w[23:20];
      f.addr = w[19:16];
      f.code = w[15:0];
      return f;
   endfunction

   function automatic dev_frame_t nop_frame();
      return pack_frame({CMD_NOP, 4'h0, 16'h0000});
   endfunction

endpackage

// File: rtl/dcs_clk_div.sv
module dcs_clk_div #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   generate
      if (HALF_DIV == 1) begin : g_direct
         assign tick = en;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !en)                   cnt <= '0;
            else if (cnt == CNT_W'(HALF_DIV-1)) cnt <= '0;
            else                                 cnt <= cnt + 1'b1;
         end
         assign tick = en && (cnt == CNT_W'(HALF_DIV-1));

         // R8: ticks are isolated when the divider is above one
         assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/dcs_frame_build.sv
module dcs_frame_build
   import dac_chain_pkg::*;
#(
   parameter int N_DEV = 3,
   parameter int IDX_W = 2
) (
   input  logic [IDX_W-1:0]          dev_idx,
   input  logic [3:0]                cmd,
   input  logic [3:0]                addr,
   input  logic [15:0]               code,
   input  logic                      use_slots,
   input  logic [N_DEV*SLOT_W-1:0]   slot_words,
   output logic [N_DEV*FRAME_W-1:0]  stream
);
   // Slot i occupies stream bits [32*i +: 32]; the top slot leaves first.
   generate
      for (genvar i = 0; i < N_DEV; i++) begin : g_slot
         dev_frame_t own;
         dev_frame_t single;
         assign own    = pack_frame(slot_words[i*SLOT_W +: SLOT_W]);
         assign single = (dev_idx == IDX_W'(i)) ? pack_frame({cmd, addr, code})
                                                : nop_frame();
         assign stream[i*FRAME_W +: FRAME_W] = use_slots ? own : single;
      end
   endgenerate
endmodule

// File: rtl/dcs_shift_engine.sv
module dcs_shift_engine
   import dac_chain_pkg::*;
#(
   parameter int N_DEV    = 3,
   parameter int HALF_DIV = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      tick,
   input  logic [N_DEV*FRAME_W-1:0]  load_word,
   output logic                      sck,
   output logic                      mosi,
   output logic                      cs_n,
   output logic                      busy,
   output logic                      done
);
   localparam int TOTAL = N_DEV * FRAME_W;
   localparam int BIT_W = $clog2(TOTAL + 1);
   localparam int HI_W  = $clog2(HALF_DIV + 2);

   typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_TRAIL} eng_state_t;

   eng_state_t        state;
   logic [TOTAL-1:0]  shreg;
   logic [BIT_W-1:0]  bit_cnt;
   logic              gap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         shreg   <= '0;
         bit_cnt <= '0;
         gap     <= 1'b0;
         sck     <= 1'b0;
         cs_n    <= 1'b1;
         busy    <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            S_IDLE: if (start) begin
               shreg <= load_word;
               cs_n  <= 1'b0;
               busy  <= 1'b1;
               gap   <= 1'b0;
               state <= S_LEAD;
            end
            S_LEAD: if (tick) begin
               gap <= ~gap;
               if (gap) state <= S_SHIFT;
            end
            S_SHIFT: if (tick) begin
               if (!sck) begin
                  sck <= 1'b1;
               end else begin
                  sck   <= 1'b0;
                  shreg <= {shreg[TOTAL-2:0], 1'b0};
                  if (bit_cnt == BIT_W'(TOTAL-1)) begin
                     bit_cnt <= '0;
                     gap     <= 1'b0;
                     state   <= S_TRAIL;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
            S_TRAIL: if (tick) begin
               gap <= ~gap;
               if (gap) begin
                  cs_n  <= 1'b1;
                  busy  <= 1'b0;
                  done  <= 1'b1;
                  state <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign mosi = shreg[TOTAL-1];

   // ---------------- checker state and assertions ----------------
   logic              sck_q;
   logic [BIT_W-1:0]  rise_cnt;
   logic [HI_W-1:0]   hi_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sck_q    <= 1'b0;
         rise_cnt <= '0;
         hi_len   <= '0;
      end else begin
         sck_q <= sck;
         if (cs_n)              rise_cnt <= '0;
         else if (sck && !sck_q) rise_cnt <= rise_cnt + 1'b1;
         if (!sck)              hi_len <= '0;
         else if (hi_len != '1) hi_len <= hi_len + 1'b1;
      end
   end

   assert_sck_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);

   assert_high_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sck) |-> (hi_len == HI_W'(HALF_DIV)));

   assert_mosi_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n) && (mosi != $past(mosi))) |-> $fell(sck));

   assert_bit_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (rise_cnt == BIT_W'(TOTAL)));

   assert_done_at_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (done && !busy));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cs_n) |=> (busy || done));
endmodule

// File: rtl/dac_chain_host.sv
module dac_chain_host
   import dac_chain_pkg::*;
#(
   parameter int N_DEV       = 3,
   parameter int HALF_DIV    = 2,
   parameter int SYS_CLK_HZ  = 50_000_000,
   parameter int SCK_MAX_HZ  = 50_000_000,
   localparam int IDX_W      = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [IDX_W-1:0]         dev_idx,
   input  logic [3:0]               cmd,
   input  logic [3:0]               addr,
   input  logic [15:0]              code,
   input  logic                     use_slots,
   input  logic [N_DEV*24-1:0]      slot_words,
   output logic                     sck,
   output logic                     mosi,
   output logic                     cs_n,
   output logic                     busy,
   output logic                     done
);
   localparam int TOTAL = N_DEV * FRAME_W;

   // R11: elaboration-time parameter checks
   initial begin
      assert_chain_len_R11: assert (N_DEV >= 1)
         else $error("chain length must be at least one");
      assert_div_nonzero_R11: assert (HALF_DIV >= 1)
         else $error("half-period divider must be at least one");
      assert_sck_rate_R11: assert ((SYS_CLK_HZ / (2 * HALF_DIV)) <= SCK_MAX_HZ)
         else $error("serial clock would exceed its maximum rate");
   end

   logic [TOTAL-1:0] stream;
   logic             tick;

   dcs_frame_build #(.N_DEV(N_DEV), .IDX_W(IDX_W)) u_build (
      .dev_idx    (dev_idx),
      .cmd        (cmd),
      .addr       (addr),
      .code       (code),
      .use_slots  (use_slots),
      .slot_words (slot_words),
      .stream     (stream)
   );

   dcs_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (busy),
      .tick  (tick)
   );

   dcs_shift_engine #(.N_DEV(N_DEV), .HALF_DIV(HALF_DIV)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .tick      (tick),
      .load_word (stream),
      .sck       (sck),
      .mosi      (mosi),
      .cs_n      (cs_n),
      .busy      (busy),
      .done      (done)
   );
endmodule

// File: tb/dac_chain_host_tb.sv
module dac_chain_host_tb;
   localparam int N_DEV    = 3;
   localparam int HALF_DIV = 2;
   localparam int TOTAL    = N_DEV * 32;
   localparam logic [31:0] NOP = 32'h00F00000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [1:0] dev_idx = '0;
   logic [3:0] cmd = '0, addr = '0;
   logic [15:0] code = '0;
   logic use_slots = 1'b0;
   logic [N_DEV*24-1:0] slot_words = '0;
   logic sck, mosi, cs_n, busy, done;

   int n_chk = 0, n_fail = 0;
   int nrise = 0;
   logic [TOTAL-1:0] cap = '0;

   always #10 clk = ~clk;

   dac_chain_host #(.N_DEV(N_DEV), .HALF_DIV(HALF_DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dev_idx(dev_idx),
      .cmd(cmd), .addr(addr), .code(code), .use_slots(use_slots),
      .slot_words(slot_words), .sck(sck), .mosi(mosi), .cs_n(cs_n),
      .busy(busy), .done(done));

   always @(posedge sck) begin
      cap   <= {cap[TOTAL-2:0], mosi};
      nrise <= nrise + 1;
   end

   task automatic chk(input logic ok, input string what,
                      input logic [TOTAL-1:0] act, input logic [TOTAL-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", what, act, exp);
      end
   endtask

   // stimulus {idx, cmd, addr, code} and the expected target frame
   localparam logic [57:0] VEC [0:5] = '{
      {2'd0, 4'h3, 4'h2, 16'hBEEF, 32'h0032BEEF},
      {2'd1, 4'h0, 4'h7, 16'h1234, 32'h00071234},
      {2'd2, 4'h2, 4'hF, 16'hFFFF, 32'h002FFFFF},
      {2'd2, 4'hF, 4'h0, 16'h0000, 32'h00F00000},
      {2'd3, 4'h3, 4'h1, 16'h5555, 32'h00315555},
      {2'd0, 4'h4, 4'h8, 16'h0001, 32'h00480001}
   };

   // R3/R4: slot k at bits [32k +: 32], slot N_DEV-1 leaves first
   function automatic logic [TOTAL-1:0] exp_stream(int idx, logic [31:0] tf);
      logic [TOTAL-1:0] s;
      for (int k = 0; k < N_DEV; k++) s[k*32 +: 32] = (k == idx) ? tf : NOP;
      return s;
   endfunction

   task automatic run_txn(input logic [1:0] idx, input logic [3:0] c, input logic [3:0] a,
                          input logic [15:0] d, input logic us,
                          input logic [N_DEV*24-1:0] sw, input logic inj,
                          input logic [TOTAL-1:0] exp, input string tag);
      int base, cyc, lead, hi;
      logic seen;
      @(negedge clk);
      dev_idx = idx; cmd = c; addr = a; code = d; use_slots = us; slot_words = sw;
      start = 1'b1;
      base = nrise;
      @(negedge clk);
      start = 1'b0;
      chk(!cs_n && busy, {tag, " R6 select low and busy after start"},
          {cs_n, busy}, 2'b01);
      cyc = 0; lead = 0; hi = 0; seen = 1'b0;
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         if (!seen) begin
            if (sck) seen = 1'b1; else lead++;
         end
         if (sck) hi++;
         if (inj && cyc == 100) begin
            start = 1'b1; dev_idx = 2'd1; code = 16'h0F0F; us = 1'b0;
         end
         if (inj && cyc == 101) start = 1'b0;
      end
      chk(done, {tag, " watchdog: done seen"}, done, 1);
      chk(cs_n && !busy, {tag, " R10 done with select high, busy low"},
          {cs_n, busy}, 2'b10);
      chk(cap == exp, {tag, " R2 R3 R4 R5 stream"}, cap, exp);
      chk(nrise - base == TOTAL, {tag, " R6 rising edge count"},
          nrise - base, TOTAL);
      chk(lead >= 2*HALF_DIV, {tag, " R8 select-to-clock gap"}, lead, 2*HALF_DIV);
      chk(hi == TOTAL*HALF_DIV, {tag, " R8 R7 clock high time"}, hi, TOTAL*HALF_DIV);
      @(negedge clk);
      chk(!done, {tag, " R10 done lasts one cycle"}, done, 0);
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(cs_n && !sck && !mosi && !busy && !done, "R1 reset state",
          {cs_n, sck, mosi, busy, done}, 5'b10000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n && !sck && !busy && !done, "R1 idle after reset release",
          {cs_n, sck, busy, done}, 4'b1000);

      // table walk, single-target mode, slot_words non-zero (R5 ignored)
      for (int v = 0; v < 6; v++) begin
         run_txn(VEC[v][57:56], VEC[v][55:52], VEC[v][51:48], VEC[v][47:32],
                 1'b0, {N_DEV{24'hA5A5A5}}, 1'b0,
                 exp_stream(int'(VEC[v][57:56]), VEC[v][31:0]),
                 $sformatf("vec%0d", v));
      end

      // R5: per-slot mode, single-target fields must be ignored
      run_txn(2'd1, 4'h3, 4'h3, 16'hDEAD, 1'b1,
              {24'h2F8000, 24'h410000, 24'h30ABCD}, 1'b0,
              {32'h002F8000, 32'h00410000, 32'h0030ABCD}, "R5 slots");

      // R9: start raised mid-transfer must not alter or repeat the transfer
      run_txn(2'd2, 4'h3, 4'h5, 16'h8001, 1'b0, '0, 1'b1,
              exp_stream(2, 32'h00358001), "R9 busy start");
      begin
         int lows = 0;
         repeat (40) begin
            @(negedge clk);
            if (!cs_n || busy) lows++;
         end
         chk(lows == 0, "R9 no second transfer after done", lows, 0);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule